// File: doc/BRIEF.md
# Home Agent Directory Snoop Filter

This block sits at the home node of a memory region. For each coherent request arriving there, it decides whether snoops go to every other node, only to chosen nodes, or to none. It also decides whether the home node's memory supplies the data. The decision draws on two sources. One is the 2-bit directory code that travels with the line in memory; the block receives it alongside the request and does not store it. The other is a small direct-mapped directory cache of 8-bit per-node presence vectors, which the block keeps itself.

A directory cache entry comes into being only when the interconnect reports that a line was forwarded from one node to another. The same event makes the block emit a write that sets the line's in-memory code to snoop-all. A request that misses the cache follows the in-memory code. A request that hits uses the presence vector and ignores the in-memory code.

All outputs are registered. A request or forward event sampled at one clock edge produces its response, or its directory write, on the next edge.

Top module: `dsf_top`

## Requirements
- R1: After reset, and in every cycle that carries no response, `rsp_valid_o`, `snoop_bcast_o`, `snoop_vec_o`, `mem_data_o` and `dir_wr_o` are all 0. After reset the directory cache holds no entries.
- R2: A request that misses the cache, with in-memory code 2'b00 (remote-invalid), responds one cycle later with no snoop (`snoop_vec_o` = 0, `snoop_bcast_o` = 0) and `mem_data_o` = 1. This holds for reads and for writes.
- R3: A missing request with code 2'b10 (snoop-all) responds with `snoop_bcast_o` = 1 and `mem_data_o` = 0. Its `snoop_vec_o` has every node bit set except the requester's bit (bit index = node ID). This holds for reads and for writes.
- R4: A missing request with code 2'b01 (shared) behaves like R2 when it is a read and like R3 when it is a write.
- R5: The unused code 2'b11 is handled exactly like snoop-all.
- R6: A forward event with line address A, source node S and destination node D has two effects. First, the cache entry at index A[IDX_W-1:0] receives full tag A. If that entry already held tag A, bits S and D are ORed into its vector; otherwise the vector becomes exactly bits S and D. Second, one cycle later `dir_wr_o` = 1, `dir_wr_addr_o` = A and `dir_wr_state_o` = 2'b10.
- R7: A read that hits an entry with two or more presence bits set issues no snoop and sets `mem_data_o` = 1. The requester's bit is added to the vector. The in-memory code has no effect.
- R8: A read that hits an entry with fewer than two presence bits set snoops exactly the set bits other than the requester's, with `snoop_bcast_o` = 0. It sets `mem_data_o` = 1 only when that target set is empty. The requester's bit is added to the vector.
- R9: A write that hits snoops exactly the set bits other than the requester's, with `snoop_bcast_o` = 0. It sets `mem_data_o` = 1 when two or more bits were set or when the target set is empty. Afterwards the vector holds only the requester's bit.
- R10: A request whose index matches a valid entry holding a different full tag is treated as a miss (R2 to R5).
- R11: When a forward event and a request fall in the same cycle, the request decides on the cache contents as they were before that edge. If both touch the same index, the forward's allocation is what the entry holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write request, 0 = read |
| req_addr_i | input | ADDR_W | Line address of request |
| req_node_i | input | NODE_W | Requesting node ID |
| mem_dir_i | input | 2 | In-memory directory code of the requested line |
| fwd_valid_i | input | 1 | Line forwarded between nodes this cycle |
| fwd_addr_i | input | ADDR_W | Line address of forwarded line |
| fwd_src_i | input | NODE_W | Node that supplied the line |
| fwd_dst_i | input | NODE_W | Node that received the line |
| rsp_valid_o | output | 1 | Decision for the previous cycle's request |
| snoop_bcast_o | output | 1 | Snoop broadcast to all other nodes |
| snoop_vec_o | output | NODES | Nodes to be snooped |
| mem_data_o | output | 1 | Home memory supplies the data |
| dir_wr_o | output | 1 | In-memory directory write strobe |
| dir_wr_addr_o | output | ADDR_W | Line address of directory write |
| dir_wr_state_o | output | 2 | New in-memory code |

## Verification
The hardest situations to reach from the ports are hits on entries that have accumulated several presence bits. A second hard case is a request and a forward event that land on the same cache index in the same cycle. Both occur only after a particular history of forwards. The stimulus therefore confines random addresses to a pool about three times the cache depth and issues forward events often. Entries then fill up, gain multiple bits, are evicted by aliasing tags, and collide with requests. A behavioural reference model checks every cycle's response against these histories.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic [1:0] {
    DIR_RINV      = 2'b00,
    DIR_SHARED    = 2'b01,
    DIR_SNOOP_ALL = 2'b10,
    DIR_RSVD      = 2'b11
  } dir_state_e;
endpackage

// File: rtl/dsf_cache.sv
module dsf_cache #(
  parameter int ADDR_W  = 16,
  parameter int NODES   = 8,
  parameter int ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [NODES-1:0]  lk_vec_o,
  input  logic              upd_en_i,
  input  logic [NODES-1:0]  upd_vec_i,
  input  logic              alloc_en_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [NODES-1:0]  alloc_bits_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic              ent_valid [ENTRIES];
  logic [ADDR_W-1:0] ent_tag   [ENTRIES];
  logic [NODES-1:0]  ent_vec   [ENTRIES];

  logic [IDX_W-1:0] lk_idx, al_idx;
  logic             al_hit;
  logic [NODES-1:0] al_vec;

  assign lk_idx   = lk_addr_i[IDX_W-1:0];
  assign al_idx   = alloc_addr_i[IDX_W-1:0];
  assign lk_hit_o = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_addr_i);
  assign lk_vec_o = ent_vec[lk_idx];
  assign al_hit   = ent_valid[al_idx] && (ent_tag[al_idx] == alloc_addr_i);
  assign al_vec   = al_hit ? (ent_vec[al_idx] | alloc_bits_i) : alloc_bits_i;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic [ADDR_W-1:0] t_q;
    logic [NODES-1:0]  p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (alloc_en_i && al_idx == IDX_W'(e)) begin
        // forward allocation wins over a same-cycle request update
        v_q <= 1'b1;
        t_q <= alloc_addr_i;
        p_q <= al_vec;
      end else if (upd_en_i && lk_idx == IDX_W'(e)) begin
        p_q <= upd_vec_i;
      end
    end
    assign ent_valid[e] = v_q;
    assign ent_tag[e]   = t_q;
    assign ent_vec[e]   = p_q;
  end

  // R6: an allocation is visible to a lookup of the same line on the next cycle
  a_r6_alloc_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i && lk_addr_i == alloc_addr_i |=> lk_hit_o || lk_addr_i != $past(alloc_addr_i));
endmodule

// File: rtl/dsf_policy.sv
module dsf_policy
  import dsf_pkg::*;
#(
  parameter int NODES = 8
) (
  input  logic             write_i,
  input  dir_state_e       mem_dir_i,
  input  logic             hit_i,
  input  logic [NODES-1:0] vec_i,
  input  logic [NODES-1:0] req_bit_i,
  output logic             bcast_o,
  output logic [NODES-1:0] snoop_vec_o,
  output logic             mem_data_o,
  output logic [NODES-1:0] upd_vec_o
);
  logic [NODES-1:0] tgt;
  logic             multi;

  assign tgt   = vec_i & ~req_bit_i;
  assign multi = $countones(vec_i) > 1;

  always_comb begin
    bcast_o     = 1'b0;
    snoop_vec_o = '0;
    mem_data_o  = 1'b1;
    upd_vec_o   = vec_i | req_bit_i;
    if (hit_i) begin
      if (!write_i && multi) begin
        mem_data_o = 1'b1;
      end else begin
        snoop_vec_o = tgt;
        mem_data_o  = multi || (tgt == '0);
      end
      if (write_i) upd_vec_o = req_bit_i;
    end else begin
      unique case (mem_dir_i)
        DIR_RINV:   bcast_o = 1'b0;
        DIR_SHARED: bcast_o = write_i;
        default:    bcast_o = 1'b1; // snoop-all and the unused code
      endcase
      if (bcast_o) begin
        snoop_vec_o = ~req_bit_i;
        mem_data_o  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsf_top.sv
module dsf_top
  import dsf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NODES      = 8,
  parameter int DC_ENTRIES = 16,
  localparam int NODE_W    = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [1:0]        mem_dir_i,
  input  logic              fwd_valid_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  input  logic [NODE_W-1:0] fwd_src_i,
  input  logic [NODE_W-1:0] fwd_dst_i,
  output logic              rsp_valid_o,
  output logic              snoop_bcast_o,
  output logic [NODES-1:0]  snoop_vec_o,
  output logic              mem_data_o,
  output logic              dir_wr_o,
  output logic [ADDR_W-1:0] dir_wr_addr_o,
  output logic [1:0]        dir_wr_state_o
);
  logic [NODES-1:0] req_bit, fwd_bits, lk_vec, upd_vec, p_snoop;
  logic             lk_hit, p_bcast, p_mem;
  logic [NODES-1:0] req_bit_q;

  assign req_bit  = NODES'(1) << req_node_i;
  assign fwd_bits = (NODES'(1) << fwd_src_i) | (NODES'(1) << fwd_dst_i);

  dsf_cache #(.ADDR_W(ADDR_W), .NODES(NODES), .ENTRIES(DC_ENTRIES)) u_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_addr_i   (req_addr_i),
    .lk_hit_o    (lk_hit),
    .lk_vec_o    (lk_vec),
    .upd_en_i    (req_valid_i && lk_hit),
    .upd_vec_i   (upd_vec),
    .alloc_en_i  (fwd_valid_i),
    .alloc_addr_i(fwd_addr_i),
    .alloc_bits_i(fwd_bits)
  );

  dsf_policy #(.NODES(NODES)) u_policy (
    .write_i    (req_write_i),
    .mem_dir_i  (dir_state_e'(mem_dir_i)),
    .hit_i      (lk_hit),
    .vec_i      (lk_vec),
    .req_bit_i  (req_bit),
    .bcast_o    (p_bcast),
    .snoop_vec_o(p_snoop),
    .mem_data_o (p_mem),
    .upd_vec_o  (upd_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      snoop_bcast_o  <= 1'b0;
      snoop_vec_o    <= '0;
      mem_data_o     <= 1'b0;
      req_bit_q      <= '0;
      dir_wr_o       <= 1'b0;
      dir_wr_addr_o  <= '0;
      dir_wr_state_o <= DIR_RINV;
    end else begin
      rsp_valid_o   <= req_valid_i;
      snoop_bcast_o <= req_valid_i && p_bcast;
      snoop_vec_o   <= req_valid_i ? p_snoop : '0;
      mem_data_o    <= req_valid_i && p_mem;
      req_bit_q     <= req_bit;
      dir_wr_o      <= fwd_valid_i;
      if (fwd_valid_i) begin
        dir_wr_addr_o  <= fwd_addr_i;
        dir_wr_state_o <= DIR_SNOOP_ALL;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !snoop_bcast_o && snoop_vec_o == '0 && !mem_data_o);
  a_r2_quiet_from_memory: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && snoop_vec_o == '0 |-> mem_data_o);
  a_r3_bcast_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && snoop_bcast_o |->
      $countones(snoop_vec_o) == NODES - 1 && (snoop_vec_o & req_bit_q) == '0 && !mem_data_o);
  a_r4_shared_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && mem_dir_i == DIR_SHARED && !lk_hit |=> !snoop_bcast_o);
  a_r6_dirwr_follows_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_i |=> dir_wr_o && dir_wr_state_o == DIR_SNOOP_ALL && dir_wr_addr_o == $past(fwd_addr_i));
  a_r8_no_self_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (snoop_vec_o & req_bit_q) == '0);
endmodule

// File: tb/dsf_top_tb.sv
module dsf_top_tb;
  localparam int ADDR_W = 16;
  localparam int NODES  = 8;
  localparam int ENT    = 16;
  localparam int NODE_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0, fwd_addr = '0;
  logic [NODE_W-1:0] req_node = '0, fwd_src = '0, fwd_dst = '0;
  logic [1:0] mem_dir = '0;
  logic fwd_valid = 0;
  logic rsp_valid, snoop_bcast, mem_data, dir_wr;
  logic [NODES-1:0] snoop_vec;
  logic [ADDR_W-1:0] dir_wr_addr;
  logic [1:0] dir_wr_state;

  always #4 clk = ~clk;

  dsf_top #(.ADDR_W(ADDR_W), .NODES(NODES), .DC_ENTRIES(ENT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_node_i(req_node), .mem_dir_i(mem_dir),
    .fwd_valid_i(fwd_valid), .fwd_addr_i(fwd_addr), .fwd_src_i(fwd_src), .fwd_dst_i(fwd_dst),
    .rsp_valid_o(rsp_valid), .snoop_bcast_o(snoop_bcast), .snoop_vec_o(snoop_vec),
    .mem_data_o(mem_data), .dir_wr_o(dir_wr), .dir_wr_addr_o(dir_wr_addr),
    .dir_wr_state_o(dir_wr_state)
  );

  int tests = 0, fails = 0;

  // reference model state
  bit              m_valid [ENT];
  bit [ADDR_W-1:0] m_tag   [ENT];
  bit [NODES-1:0]  m_vec   [ENT];

  // expected outputs
  bit e_rv, e_bc, e_md, e_dw;
  bit [NODES-1:0] e_sv;
  bit [ADDR_W-1:0] e_da;
  string e_tag;

  function automatic int popc(bit [NODES-1:0] v);
    int n = 0;
    for (int i = 0; i < NODES; i++) n += v[i];
    return n;
  endfunction

  task automatic model_step();
    int idx, fidx;
    bit hit, multi, snall, f_hit;
    bit [NODES-1:0] rb, tgt, nv, fb, f_vec;
    idx  = int'(req_addr) % ENT;
    fidx = int'(fwd_addr) % ENT;
    rb   = NODES'(1) << req_node;
    fb   = (NODES'(1) << fwd_src) | (NODES'(1) << fwd_dst);
    f_hit = m_valid[fidx] && m_tag[fidx] == fwd_addr;
    f_vec = f_hit ? (m_vec[fidx] | fb) : fb;
    hit  = m_valid[idx] && m_tag[idx] == req_addr;
    e_rv = req_valid; e_bc = 0; e_sv = '0; e_md = 0; e_tag = "R1";
    if (req_valid) begin
      if (hit) begin
        tgt = m_vec[idx] & ~rb;
        multi = popc(m_vec[idx]) >= 2;
        if (!req_write) begin
          if (multi) begin e_md = 1; e_tag = "R7"; end
          else begin e_sv = tgt; e_md = (tgt == 0); e_tag = "R8"; end
          nv = m_vec[idx] | rb;
        end else begin
          e_sv = tgt; e_md = multi || (tgt == 0); e_tag = "R9";
          nv = rb;
        end
        m_vec[idx] = nv;
      end else begin
        snall = (mem_dir >= 2) || (mem_dir == 1 && req_write);
        if (snall) begin e_bc = 1; e_sv = ~rb; e_md = 0; end
        else e_md = 1;
        case (mem_dir)
          2'd0: e_tag = "R2";
          2'd1: e_tag = "R4";
          2'd2: e_tag = "R3";
          default: e_tag = "R5";
        endcase
        if (m_valid[idx]) e_tag = "R10";
      end
      if (fwd_valid && fidx == idx) e_tag = "R11";
    end
    e_dw = fwd_valid; e_da = fwd_addr;
    if (fwd_valid) begin
      m_valid[fidx] = 1; m_tag[fidx] = fwd_addr; m_vec[fidx] = f_vec;
    end
  endtask

  task automatic compare();
    tests++;
    if (rsp_valid !== e_rv || snoop_bcast !== e_bc || snoop_vec !== e_sv || mem_data !== e_md) begin
      fails++;
      $display("FAIL %s rsp: got v=%0b b=%0b vec=%02h m=%0b exp v=%0b b=%0b vec=%02h m=%0b",
               e_tag, rsp_valid, snoop_bcast, snoop_vec, mem_data, e_rv, e_bc, e_sv, e_md);
    end
    tests++;
    if (dir_wr !== e_dw || (e_dw && (dir_wr_addr !== e_da || dir_wr_state !== 2'b10))) begin
      fails++;
      $display("FAIL R6 dir: got w=%0b a=%04h s=%0d exp w=%0b a=%04h s=2",
               dir_wr, dir_wr_addr, dir_wr_state, e_dw, e_da);
    end
  endtask

  task automatic drive_rand(int fwd_pct);
    req_valid = ($urandom_range(99) < 75);
    req_write = $urandom_range(1);
    req_addr  = ADDR_W'($urandom_range(47));
    req_node  = NODE_W'($urandom_range(NODES - 1));
    mem_dir   = 2'($urandom_range(3));
    fwd_valid = ($urandom_range(99) < fwd_pct);
    fwd_addr  = ADDR_W'($urandom_range(47));
    fwd_src   = NODE_W'($urandom_range(NODES - 1));
    fwd_dst   = NODE_W'($urandom_range(NODES - 1));
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_vec[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (rsp_valid !== 0 || dir_wr !== 0 || snoop_vec !== 0 || mem_data !== 0 || snoop_bcast !== 0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b w=%0b vec=%02h exp all 0", rsp_valid, dir_wr, snoop_vec);
    end
    rst_ni = 1'b1;
    // directed: R2/R3/R4/R5 misses on an empty cache, one per code and direction
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req_valid = 1; req_write = k[0]; mem_dir = 2'(k >> 1);
      req_addr = ADDR_W'(100 + k); req_node = NODE_W'(k); fwd_valid = 0;
      @(posedge clk); model_step();
      @(negedge clk); compare();
    end
    // directed: R6 then R7/R8/R9 on one line
    @(negedge clk);
    req_valid = 0; fwd_valid = 1; fwd_addr = 16'h0005; fwd_src = 3'd1; fwd_dst = 3'd2;
    @(posedge clk); model_step(); @(negedge clk); compare();
    req_valid = 1; req_write = 0; req_addr = 16'h0005; req_node = 3'd4; mem_dir = 2'd0;
    fwd_valid = 0;
    @(posedge clk); model_step(); @(negedge clk); compare();   // R7
    req_write = 1; req_node = 3'd1;
    @(posedge clk); model_step(); @(negedge clk); compare();   // R9
    req_write = 0; req_node = 3'd6;
    @(posedge clk); model_step(); @(negedge clk); compare();   // R8 single owner
    // R10: alias on same index
    req_addr = 16'h0015; mem_dir = 2'd2;
    @(posedge clk); model_step(); @(negedge clk); compare();
    // R11: same-cycle forward and request on one index
    req_addr = 16'h0005; fwd_valid = 1; fwd_addr = 16'h0015; fwd_src = 3'd0; fwd_dst = 3'd3;
    @(posedge clk); model_step(); @(negedge clk); compare();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      drive_rand(c < 2000 ? 40 : 15);
      @(posedge clk); model_step();
      @(negedge clk); compare();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule